// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block raises a wake-up event when a running calendar reaches a programmed moment. The seven calendar fields (seconds, minutes, hours, weekday, day of month, month, year) arrive as BCD values on plain input ports, together with a one-cycle pulse that marks each new second. Software programs the alarm through a small register bus. Each alarm field holds a BCD value and its own match-enable flag. Writes land in a staging copy, and a separate commit write moves all staged fields into the active copy in one step. Only the active copy takes part in the comparison.

On every seconds pulse, the comparator checks each active field that has its enable set against the calendar. When all enabled fields agree, a sticky pending flag is set. The interrupt line is the pending flag gated by an interrupt-enable flag. Software clears the pending flag by writing a 1 to it. Disabled fields, the weekday field being the usual case, are left out of the comparison.

The register bus is a plain control path with no back-pressure. A write takes effect on the clock edge that samples it. A read returns its data on `bus_rdata` one cycle after `bus_rd` is sampled.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, the pending flag, the interrupt line, the interrupt enable, every field value and every field enable read as zero.
- R2: Register indices 0 to 6 hold the staged fields in the order seconds, minutes, hours, weekday, day, month, year. Data bit 15 is the field's match enable, and the low bits hold the BCD value. A read of indices 0 to 6 returns the active copy, so a staged write alone does not change the read value.
- R3: A write to index 7 with bit 15 set copies all seven staged fields and enables into the active copy. A write to index 7 with bit 15 clear has no effect.
- R4: Field values are truncated to their widths: 7 bits for seconds and minutes, 6 bits for hours, 3 bits for weekday, 6 bits for day, 5 bits for month and 8 bits for year.
- R5: On a clock edge where `sec_tick` is high and every enabled active field equals its calendar input, the pending flag (index 9, bit 0) reads 1 from the next cycle. Disabled fields do not take part, and a mismatch in any enabled field prevents the set.
- R6: Without `sec_tick`, a matching calendar does not set the pending flag.
- R7: When no field enable is set, the pending flag never sets.
- R8: Writing index 9 with bit 0 set clears the pending flag, and writing it with bit 0 clear has no effect. If a set and a clear fall on the same edge, the set wins.
- R9: `alarm_irq` is high exactly when the pending flag and the interrupt enable (index 8, bit 0) are both set. Clearing the enable drops the line but leaves the pending flag set.
- R10: Once set, the pending flag stays set across later seconds pulses, matching or not, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after bus_rd |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_wday | input | 3 | Calendar weekday |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year offset, BCD |
| sec_tick | input | 1 | One-cycle pulse per second |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions check, on every cycle, the rules for the pending flag. It sets after a matching tick and never without one. A write of 1 clears it unless a set falls on the same edge. It holds until cleared. The comparator never reports a hit while every enable is clear, and the interrupt line never rises without both the pending flag and the enable. Only the bench scenarios can show that staged values stay out of the comparison until a commit, that field values are truncated, that a commit write without its trigger bit is ignored, and that a disabled weekday mismatch still allows a match.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_MAX_W = 8;

  // register indices; field slots follow the field order below
  localparam int IDX_COMMIT = 7;
  localparam int IDX_IEN    = 8;
  localparam int IDX_STAT   = 9;

  typedef logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] field_vec_t;

  // field order: sec, min, hour, wday, day, mon, year
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2:       return 6;
      3:       return 3;
      4:       return 6;
      5:       return 5;
      default: return 8;
    endcase
  endfunction

  function automatic logic [FIELD_MAX_W-1:0] field_mask(input int idx);
    return FIELD_MAX_W'((1 << field_width(idx)) - 1);
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              status,
  output field_vec_t        act_val,
  output logic [NUM_FIELDS-1:0] act_en,
  output logic              ien,
  output logic              stat_clr
);
  localparam int FLAG_BIT = DATA_W - 1;

  field_vec_t            stg_val;
  logic [NUM_FIELDS-1:0] stg_en;
  logic                  commit;
  logic [DATA_W-1:0]     rd_word;

  assign commit   = bus_wr && (bus_addr == ADDR_W'(IDX_COMMIT)) && bus_wdata[FLAG_BIT];
  assign stat_clr = bus_wr && (bus_addr == ADDR_W'(IDX_STAT)) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_val <= '0;
      stg_en  <= '0;
      act_val <= '0;
      act_en  <= '0;
      ien     <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (bus_wr && (bus_addr == ADDR_W'(i))) begin
          stg_val[i] <= bus_wdata[FIELD_MAX_W-1:0] & field_mask(i);
          stg_en[i]  <= bus_wdata[FLAG_BIT];
        end
      end
      if (commit) begin
        act_val <= stg_val;
        act_en  <= stg_en;
      end
      if (bus_wr && (bus_addr == ADDR_W'(IDX_IEN)))
        ien <= bus_wdata[0];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (bus_addr == ADDR_W'(i)) begin
        rd_word[FLAG_BIT]          = act_en[i];
        rd_word[FIELD_MAX_W-1:0]   = act_val[i];
      end
    end
    if (bus_addr == ADDR_W'(IDX_IEN))  rd_word[0] = ien;
    if (bus_addr == ADDR_W'(IDX_STAT)) rd_word[0] = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/alm_match.sv
module alm_match
  import cal_alarm_pkg::*;
(
  input  field_vec_t            act_val,
  input  logic [NUM_FIELDS-1:0] act_en,
  input  field_vec_t            cur_val,
  output logic                  hit
);
  logic [NUM_FIELDS-1:0] agree;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign agree[g] = !act_en[g] || (act_val[g] == cur_val[g]);
  end

  assign hit = (|act_en) && (&agree);
endmodule

// File: rtl/alm_status.sv
module alm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic hit,
  input  logic clr,
  input  logic ien,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               status <= 1'b0;
    else if (sec_tick && hit) status <= 1'b1;
    else if (clr)             status <= 1'b0;
  end

  assign irq = status & ien;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [6:0]        cal_sec,
  input  logic [6:0]        cal_min,
  input  logic [5:0]        cal_hour,
  input  logic [2:0]        cal_wday,
  input  logic [5:0]        cal_day,
  input  logic [4:0]        cal_mon,
  input  logic [7:0]        cal_year,
  input  logic              sec_tick,
  output logic              alarm_irq
);
  field_vec_t            act_val;
  field_vec_t            cur_val;
  logic [NUM_FIELDS-1:0] act_en;
  logic                  ien;
  logic                  stat_clr;
  logic                  status_q;
  logic                  hit;

  assign cur_val[0] = FIELD_MAX_W'(cal_sec);
  assign cur_val[1] = FIELD_MAX_W'(cal_min);
  assign cur_val[2] = FIELD_MAX_W'(cal_hour);
  assign cur_val[3] = FIELD_MAX_W'(cal_wday);
  assign cur_val[4] = FIELD_MAX_W'(cal_day);
  assign cur_val[5] = FIELD_MAX_W'(cal_mon);
  assign cur_val[6] = FIELD_MAX_W'(cal_year);

  alm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status(status_q), .act_val(act_val), .act_en(act_en),
    .ien(ien), .stat_clr(stat_clr)
  );

  alm_match u_match (
    .act_val(act_val), .act_en(act_en), .cur_val(cur_val), .hit(hit)
  );

  alm_status u_status (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hit(hit),
    .clr(stat_clr), .ien(ien), .status(status_q), .irq(alarm_irq)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int NF = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic          hit,
  input logic          status,
  input logic          stat_clr,
  input logic          ien,
  input logic [NF-1:0] act_en,
  input logic          irq
);
  // R5
  p_set_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> status);
  // R6
  p_no_tick_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !status) |=> !status);
  // R7
  p_no_enable_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en == '0) |-> !hit);
  // R8
  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && stat_clr && !(sec_tick && hit)) |=> !status);
  // R10
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !stat_clr) |=> status);
  // R9
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && ien));
endmodule

bind cal_alarm_match cal_alarm_chk #(.NF(cal_alarm_pkg::NUM_FIELDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hit(hit),
  .status(status_q), .stat_clr(stat_clr), .ien(ien),
  .act_en(act_en), .irq(alarm_irq)
);

// File: tb/tb_cal_alarm_match.sv
`timescale 1ns/1ps
module tb_cal_alarm_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [6:0]  cal_sec = '0, cal_min = '0;
  logic [5:0]  cal_hour = '0, cal_day = '0;
  logic [2:0]  cal_wday = '0;
  logic [4:0]  cal_mon = '0;
  logic [7:0]  cal_year = '0;
  logic        sec_tick = 1'b0;
  logic        alarm_irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  cal_alarm_match dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_wday(cal_wday), .cal_day(cal_day), .cal_mon(cal_mon),
    .cal_year(cal_year), .sec_tick(sec_tick), .alarm_irq(alarm_irq)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read got=%h exp=none", "scoreboard", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: rdata got=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (alarm_irq !== e) begin
      bad++;
      $display("FAIL %s: alarm_irq got=%b exp=%b", t, alarm_irq, e);
    end
  endtask

  task automatic set_cal_match();
    cal_sec = 7'h30; cal_min = 7'h15; cal_hour = 6'h12; cal_wday = 3'd3;
    cal_day = 6'h21; cal_mon = 5'h06; cal_year = 8'h55;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd_expect(4'd0, 16'h0000, "R1 field");
    rd_expect(4'd9, 16'h0000, "R1 status");
    rd_expect(4'd8, 16'h0000, "R1 ien");
    // R7 no enables: zero calendar equals zero fields, still no fire
    tick_once();
    rd_expect(4'd9, 16'h0000, "R7 no enables");
    // R2 staged write not visible before commit
    wr(4'd0, 16'h8030);
    rd_expect(4'd0, 16'h0000, "R2 staged only");
    // R3 commit without trigger bit ignored
    wr(4'd7, 16'h0001);
    rd_expect(4'd0, 16'h0000, "R3 no trigger");
    wr(4'd7, 16'h8000);
    rd_expect(4'd0, 16'h8030, "R3 commit");
    // R4 truncation of hours to 6 bits and month to 5 bits
    wr(4'd2, 16'h80FF);
    wr(4'd5, 16'h80FF);
    wr(4'd7, 16'h8000);
    rd_expect(4'd2, 16'h803F, "R4 hour width");
    rd_expect(4'd5, 16'h801F, "R4 month width");
    // program full alarm; weekday left disabled with a mismatching value
    wr(4'd1, 16'h8015);
    wr(4'd2, 16'h8012);
    wr(4'd3, 16'h0005);
    wr(4'd4, 16'h8021);
    wr(4'd5, 16'h8006);
    wr(4'd6, 16'h8055);
    wr(4'd7, 16'h8000);
    rd_expect(4'd3, 16'h0005, "R2 weekday disabled");
    set_cal_match();
    // R6 matching calendar without tick
    repeat (3) @(negedge clk);
    rd_expect(4'd9, 16'h0000, "R6 no tick");
    // R5 tick with match (disabled weekday differs)
    tick_once();
    rd_expect(4'd9, 16'h0001, "R5 match");
    chk_irq(1'b0, "R9 ien off");
    // R8 writing zero no effect
    wr(4'd9, 16'h0000);
    rd_expect(4'd9, 16'h0001, "R8 write zero");
    // R9 gating
    wr(4'd8, 16'h0001);
    chk_irq(1'b1, "R9 ien on");
    wr(4'd8, 16'h0000);
    chk_irq(1'b0, "R9 ien cleared");
    rd_expect(4'd9, 16'h0001, "R9 status kept");
    wr(4'd8, 16'h0001);
    wr(4'd9, 16'h0001);
    chk_irq(1'b0, "R8 clear drops irq");
    rd_expect(4'd9, 16'h0000, "R8 cleared");
    // R5 mismatch on minutes
    cal_min = 7'h16;
    tick_once();
    rd_expect(4'd9, 16'h0000, "R5 mismatch");
    // R10 sticky across mismatching ticks
    cal_min = 7'h15;
    tick_once();
    cal_sec = 7'h31;
    tick_once();
    tick_once();
    rd_expect(4'd9, 16'h0001, "R10 sticky");
    chk_irq(1'b1, "R10 irq held");
    // R8 set wins over simultaneous clear
    wr(4'd9, 16'h0001);
    rd_expect(4'd9, 16'h0000, "R8 clear before race");
    cal_sec = 7'h30;
    @(negedge clk);
    sec_tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd9; bus_wdata = 16'h0001;
    @(negedge clk);
    sec_tick = 1'b0; bus_wr = 1'b0;
    rd_expect(4'd9, 16'h0001, "R8 set wins");
    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: leftover got=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule